// File: doc/BRIEF.md
# Interrupt entry sequencer

This block sits beside the fetch-execute control of a small processor. Each time the processor is about to fetch an instruction, the block looks at the device-interrupt flag and the controller identifier that the I/O side drives. If no interrupt is waiting, the fetch goes ahead in the same cycle, so the check adds no cycle. If an unmasked interrupt is pending, the block holds the fetch back and runs a fixed four-cycle entry sequence. The sequence drives the processor's own write ports.

The sequence runs in this order. First it pushes the link register (r6) onto a stack that grows downward, with r5 as the stack pointer. Next it lowers r5 by one word. Then it copies the current program counter into r6. Finally it loads a new program counter from a jump table. The table entry is found from a base address, written once at boot, plus four times the controller ID. That ID is captured when the interrupt is taken.

Entry masks further interrupts. A return-from-interrupt strobe copies r6 back into the program counter and lifts the mask.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle. All write strobes (mem_we_o, rf_we_o, pc_we_o, tbl_re_o) and busy_o are low, the mask is clear, and the table base is 0. With irq_i low, fetch_ok_o equals fetch_req_i.
- R2: When fetch_req_i and irq_i are both high while the block is idle and unmasked, the interrupt is taken. In that cycle fetch_ok_o is low. With fetch_req_i low, no entry starts, whatever irq_i is.
- R3: The first cycle after the interrupt is taken (the store step) drives mem_we_o high, with mem_addr_o = r5_i − 4 and mem_wdata_o = r6_i.
- R4: The second step drives rf_we_o high, with rf_sel_o = 5 and rf_wdata_o = r5_i − 4.
- R5: The third step drives rf_we_o high, with rf_sel_o = 6 and rf_wdata_o = pc_i.
- R6: The fourth step drives tbl_re_o high, with tbl_addr_o = base + 4 × ID. It also drives pc_we_o high with pc_wdata_o = tbl_rdata_i, read in the same cycle.
- R7: busy_o is high for exactly the four steps. fetch_ok_o is low throughout, and each step raises only its own strobe.
- R8: From the cycle after the interrupt is taken until a return strobe is accepted, irq_i is ignored: an idle cycle with fetch_req_i high gives fetch_ok_o high.
- R9: An iret_i pulse while idle drives pc_we_o with pc_wdata_o = r6_i and clears the mask from the next cycle. If iret_i and irq_i arrive together while masked, no entry starts in that cycle; the interrupt is taken at the next fetch.
- R10: base_we_i loads base_wdata_i into the table base at the clock edge. A write made during a vector step does not change that step's tbl_addr_o, and it is used by the next entry.
- R11: The ID is captured when the interrupt is taken. Changes on irq_id_i during the sequence do not change tbl_addr_o.
- R12: iret_i while busy_o is high is ignored: no pc_we_o in a store step, and the mask stays set after the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Processor wants to fetch an instruction this cycle |
| irq_i | input | 1 | Device interrupt pending |
| irq_id_i | input | 4 | Identifier of the interrupting controller |
| iret_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 32 | Current program counter |
| r5_i | input | 32 | Stack pointer register value |
| r6_i | input | 32 | Link register value |
| base_we_i | input | 1 | Boot-time write of the jump table base |
| base_wdata_i | input | 32 | New jump table base |
| tbl_rdata_i | input | 32 | Jump table read data (same cycle) |
| fetch_ok_o | output | 1 | Fetch may proceed this cycle |
| busy_o | output | 1 | Entry sequence running |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory write address |
| mem_wdata_o | output | 32 | Memory write data |
| rf_we_o | output | 1 | Register file write strobe |
| rf_sel_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| tbl_re_o | output | 1 | Jump table read strobe |
| tbl_addr_o | output | 32 | Jump table read address |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_wdata_o | output | 32 | New program counter |

## Verification
A return strobe and a pending interrupt can land in the same cycle, and both compete for the program counter write and the mask. The bench raises iret_i while irq_i and fetch_req_i are held high after an entry. It then requires that cycle to restore the program counter from r6 with no entry starting, and the next fetch to start a fresh entry. A table-base write in the same cycle as a vector step is provoked too: that step must still use the old base, and the following entry the new one.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_STORE = 3'd1,
    SQ_DEC   = 3'd2,
    SQ_SAVE  = 3'd3,
    SQ_VEC   = 3'd4
  } sq_state_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_req_i,
  input  logic irq_i,
  input  logic iret_i,
  input  logic idle_i,
  output logic take_o,
  output logic iret_ack_o,
  output logic mask_o
);
  logic mask_q;

  assign take_o     = fetch_req_i & irq_i & ~mask_q & idle_i;
  assign iret_ack_o = iret_i & idle_i;
  assign mask_o     = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= 1'b0;
    else if (take_o)     mask_q <= 1'b1;
    else if (iret_ack_o) mask_q <= 1'b0;
  end
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
  import irq_seq_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [ID_W-1:0] irq_id_i,
  output sq_state_e       state_o,
  output logic [ID_W-1:0] id_o
);
  sq_state_e       state_q, state_d;
  logic [ID_W-1:0] id_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (take_i) state_d = SQ_STORE;
      SQ_STORE: state_d = SQ_DEC;
      SQ_DEC:   state_d = SQ_SAVE;
      SQ_SAVE:  state_d = SQ_VEC;
      SQ_VEC:   state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_i) id_q <= irq_id_i;
    end
  end

  assign state_o = state_q;
  assign id_o    = id_q;
endmodule

// File: rtl/vec_base_reg.sv
module vec_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_o <= '0;
    else if (we_i) base_o <= wdata_i;
  end
endmodule

// File: rtl/irq_port_mux.sv
module irq_port_mux
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int REG_W      = 3,
  parameter int SP_IDX     = 5,
  parameter int LR_IDX     = 6,
  parameter int WORD_BYTES = 4
) (
  input  sq_state_e         state_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              iret_ack_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] r5_i,
  input  logic [ADDR_W-1:0] r6_i,
  input  logic [ADDR_W-1:0] tbl_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_sel_o,
  output logic [ADDR_W-1:0] rf_wdata_o,
  output logic              tbl_re_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_wdata_o
);
  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(WORD_BYTES);
  localparam logic [REG_W-1:0]  SP   = REG_W'(SP_IDX);
  localparam logic [REG_W-1:0]  LR   = REG_W'(LR_IDX);

  logic [ADDR_W-1:0] sp_dec;
  logic [ADDR_W-1:0] slot_ofs;

  assign sp_dec   = r5_i - WORD;
  assign slot_ofs = ADDR_W'(id_i) * WORD;

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    rf_we_o     = 1'b0;
    rf_sel_o    = '0;
    rf_wdata_o  = '0;
    tbl_re_o    = 1'b0;
    tbl_addr_o  = '0;
    pc_we_o     = 1'b0;
    pc_wdata_o  = '0;
    unique case (state_i)
      SQ_STORE: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_dec;
        mem_wdata_o = r6_i;
      end
      SQ_DEC: begin
        rf_we_o    = 1'b1;
        rf_sel_o   = SP;
        rf_wdata_o = sp_dec;
      end
      SQ_SAVE: begin
        rf_we_o    = 1'b1;
        rf_sel_o   = LR;
        rf_wdata_o = pc_i;
      end
      SQ_VEC: begin
        tbl_re_o   = 1'b1;
        tbl_addr_o = base_i + slot_ofs;
        pc_we_o    = 1'b1;
        pc_wdata_o = tbl_rdata_i;
      end
      default: begin
        if (iret_ack_i) begin
          pc_we_o    = 1'b1;
          pc_wdata_o = r6_i;
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int REG_W      = 3,
  parameter int SP_IDX     = 5,
  parameter int LR_IDX     = 6,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic              irq_i,
  input  logic [ID_W-1:0]   irq_id_i,
  input  logic              iret_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] r5_i,
  input  logic [ADDR_W-1:0] r6_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  input  logic [ADDR_W-1:0] tbl_rdata_i,
  output logic              fetch_ok_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_sel_o,
  output logic [ADDR_W-1:0] rf_wdata_o,
  output logic              tbl_re_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  output logic              pc_we_o,
  output logic [ADDR_W-1:0] pc_wdata_o
);
  sq_state_e         state;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] base_q;
  logic              idle, take, iret_ack, mask_q;

  assign idle       = (state == SQ_IDLE);
  assign busy_o     = ~idle;
  // interrupt check shares the fetch cycle
  assign fetch_ok_o = fetch_req_i & idle & ~take;

  irq_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_req_i(fetch_req_i),
    .irq_i      (irq_i),
    .iret_i     (iret_i),
    .idle_i     (idle),
    .take_o     (take),
    .iret_ack_o (iret_ack),
    .mask_o     (mask_q)
  );

  irq_fsm #(.ID_W(ID_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .irq_id_i(irq_id_i),
    .state_o (state),
    .id_o    (id_q)
  );

  vec_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (base_we_i),
    .wdata_i(base_wdata_i),
    .base_o (base_q)
  );

  irq_port_mux #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .REG_W(REG_W),
    .SP_IDX(SP_IDX), .LR_IDX(LR_IDX), .WORD_BYTES(WORD_BYTES)
  ) u_mux (
    .state_i    (state),
    .id_i       (id_q),
    .base_i     (base_q),
    .iret_ack_i (iret_ack),
    .pc_i       (pc_i),
    .r5_i       (r5_i),
    .r6_i       (r6_i),
    .tbl_rdata_i(tbl_rdata_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .rf_we_o    (rf_we_o),
    .rf_sel_o   (rf_sel_o),
    .rf_wdata_o (rf_wdata_o),
    .tbl_re_o   (tbl_re_o),
    .tbl_addr_o (tbl_addr_o),
    .pc_we_o    (pc_we_o),
    .pc_wdata_o (pc_wdata_o)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 3,
  parameter int SP_IDX = 5,
  parameter int LR_IDX = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_i,
  input logic              irq_i,
  input logic              iret_i,
  input logic              busy_o,
  input logic              fetch_ok_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rf_we_o,
  input logic [REG_W-1:0]  rf_sel_o,
  input logic [ADDR_W-1:0] rf_wdata_o,
  input logic              tbl_re_o,
  input logic [ADDR_W-1:0] tbl_addr_o,
  input logic              pc_we_o,
  input logic              mask_q
);
  localparam logic [REG_W-1:0] SP = REG_W'(SP_IDX);
  localparam logic [REG_W-1:0] LR = REG_W'(LR_IDX);

  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && irq_i && !mask_q && !busy_o && !iret_i) |=> mem_we_o);

  p_dec_after_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (rf_we_o && rf_sel_o == SP && rf_wdata_o == $past(mem_addr_o)));

  p_save_after_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_sel_o == SP) |=> (rf_we_o && rf_sel_o == LR));

  p_vec_after_save_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_sel_o == LR) |=> (tbl_re_o && pc_we_o && tbl_addr_o[1:0] == 2'b00));

  p_busy_blocks_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !fetch_ok_o);

  p_one_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, rf_we_o, tbl_re_o}));

  p_mask_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_re_o |=> mask_q);

  p_iret_unmask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && !busy_o && !(fetch_req_i && irq_i && !mask_q)) |=> !mask_q);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fetch_req_i(fetch_req_i),
  .irq_i      (irq_i),
  .iret_i     (iret_i),
  .busy_o     (busy_o),
  .fetch_ok_o (fetch_ok_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .rf_we_o    (rf_we_o),
  .rf_sel_o   (rf_sel_o),
  .rf_wdata_o (rf_wdata_o),
  .tbl_re_o   (tbl_re_o),
  .tbl_addr_o (tbl_addr_o),
  .pc_we_o    (pc_we_o),
  .mask_q     (mask_q)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_i = 1'b0, irq_i = 1'b0, iret_i = 1'b0, base_we_i = 1'b0;
  logic [3:0]  irq_id_i = '0;
  logic [31:0] pc_i = '0, r5_i = '0, r6_i = '0, base_wdata_i = '0, tbl_rdata_i;
  logic        fetch_ok_o, busy_o, mem_we_o, rf_we_o, tbl_re_o, pc_we_o;
  logic [2:0]  rf_sel_o;
  logic [31:0] mem_addr_o, mem_wdata_o, rf_wdata_o, tbl_addr_o, pc_wdata_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  // table model: entry content derived from its address
  assign tbl_rdata_i = {tbl_addr_o[15:0], 16'hBEEF};

  irq_entry_seq u0 (.*);

  localparam int NV = 4;
  localparam logic [3:0]  V_ID [NV] = '{4'd0, 4'd15, 4'd7, 4'd2};
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_1000, 32'h0004_0200, 32'hFFFF_FF00};
  localparam logic [31:0] V_R5 [NV] = '{32'h0000_8000, 32'h0000_7FFC, 32'h0000_0004, 32'h0000_0000};
  localparam logic [31:0] V_R6 [NV] = '{32'h1111_2222, 32'hDEAD_0001, 32'h0, 32'hCAFE_F00D};
  localparam logic [31:0] V_PC [NV] = '{32'h0000_0100, 32'h0000_0A04, 32'h0012_3450, 32'h8000_0000};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic write_base(logic [31:0] b);
    cyc(); base_we_i = 1'b1; base_wdata_i = b;
    cyc(); base_we_i = 1'b0;
  endtask

  // drive detect cycle then check the four steps; irq_id_i is scrambled mid-sequence
  task automatic entry(logic [3:0] id, logic [31:0] base, logic [31:0] r5,
                       logic [31:0] r6, logic [31:0] pc, logic new_base_in_vec,
                       logic [31:0] new_base);
    cyc(); fetch_req_i = 1'b1; irq_i = 1'b1; irq_id_i = id;
    r5_i = r5; r6_i = r6; pc_i = pc;
    #1 check("R2 detect fetch_ok", 32'(fetch_ok_o), 0);
    cyc(); irq_id_i = ~id;
    #1 check("R3 store we", 32'(mem_we_o), 1);
    check("R3 store addr", mem_addr_o, r5 - 32'd4);
    check("R3 store data", mem_wdata_o, r6);
    check("R7 busy store", 32'({busy_o, fetch_ok_o, rf_we_o, tbl_re_o}), 32'b1000);
    cyc();
    #1 check("R4 dec we/sel", 32'({rf_we_o, rf_sel_o, mem_we_o}), 32'b1_101_0);
    check("R4 dec data", rf_wdata_o, r5 - 32'd4);
    cyc();
    #1 check("R5 save we/sel", 32'({rf_we_o, rf_sel_o}), 32'b1_110);
    check("R5 save data", rf_wdata_o, pc);
    cyc();
    if (new_base_in_vec) begin base_we_i = 1'b1; base_wdata_i = new_base; end
    #1 check("R6 R11 vec addr", tbl_addr_o, base + {26'd0, id, 2'b00});
    check("R6 vec pc", 32'({pc_we_o, tbl_re_o, rf_we_o}), 32'b110);
    check("R6 vec pc data", pc_wdata_o, {tbl_addr_o[15:0], 16'hBEEF});
    check("R7 busy vec", 32'({busy_o, fetch_ok_o}), 32'b10);
    cyc(); base_we_i = 1'b0;
    #1 check("R7 R8 idle masked fetch_ok", 32'({busy_o, fetch_ok_o, mem_we_o}), 32'b010);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #1 check("R1 reset strobes", 32'({mem_we_o, rf_we_o, pc_we_o, tbl_re_o, busy_o}), 0);
    cyc(); rst_ni = 1'b1;
    cyc(); fetch_req_i = 1'b1;
    #1 check("R1 fetch follows req", 32'(fetch_ok_o), 1);
    cyc(); fetch_req_i = 1'b0;
    #1 check("R1 fetch follows req low", 32'(fetch_ok_o), 0);

    // R1 base resets to 0: first entry uses base 0
    entry(4'd3, 32'h0, 32'h100, 32'h5, 32'h40, 1'b0, 32'h0);
    cyc(); iret_i = 1'b1; irq_i = 1'b0; r6_i = 32'h40;
    #1 check("R9 iret pc", 32'({pc_we_o}), 1);
    check("R9 iret data", pc_wdata_o, 32'h40);
    cyc(); iret_i = 1'b0;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      write_base(V_BASE[i]);
      entry(V_ID[i], V_BASE[i], V_R5[i], V_R6[i], V_PC[i], 1'b0, 32'h0);
      cyc(); iret_i = 1'b1; irq_i = 1'b1; r6_i = V_PC[i];
      #1 check("R9 iret+irq pc_we", 32'({pc_we_o, fetch_ok_o}), 32'b11);
      check("R9 iret+irq data", pc_wdata_o, V_PC[i]);
      cyc(); iret_i = 1'b0;
      #1 check("R9 taken at next fetch", 32'(fetch_ok_o), 0);
      cyc(); fetch_req_i = 1'b0; irq_i = 1'b0;
      #1 check("R9 second entry store", 32'(mem_we_o), 1);
      for (int k = 0; k < 4; k++) cyc();
      iret_i = 1'b1;
      cyc(); iret_i = 1'b0;
    end

    // R2 no entry without fetch request
    cyc(); fetch_req_i = 1'b0; irq_i = 1'b1;
    cyc();
    #1 check("R2 no req no entry", 32'({busy_o, mem_we_o}), 0);
    irq_i = 1'b0;

    // R10 base write during vector step
    write_base(32'h0000_2000);
    entry(4'd1, 32'h0000_2000, 32'h400, 32'h9, 32'h80, 1'b1, 32'h0000_3000);
    cyc(); fetch_req_i = 1'b0; irq_i = 1'b0; iret_i = 1'b1;
    cyc(); iret_i = 1'b0;
    entry(4'd1, 32'h0000_3000, 32'h400, 32'h9, 32'h80, 1'b0, 32'h0);
    cyc(); fetch_req_i = 1'b0; irq_i = 1'b0; iret_i = 1'b1;
    cyc(); iret_i = 1'b0;

    // R12 iret during busy ignored
    cyc(); fetch_req_i = 1'b1; irq_i = 1'b1; irq_id_i = 4'd5;
    cyc(); iret_i = 1'b1;
    #1 check("R12 no pc_we in store", 32'({pc_we_o, mem_we_o}), 32'b01);
    cyc(); iret_i = 1'b0;
    cyc(); cyc(); cyc();
    #1 check("R12 mask kept", 32'({fetch_ok_o, busy_o}), 32'b10);
    cyc(); fetch_req_i = 1'b0; irq_i = 1'b0; iret_i = 1'b1;
    cyc(); iret_i = 1'b0; fetch_req_i = 1'b1;
    #1 check("R1 idle after return", 32'({fetch_ok_o, busy_o}), 32'b10);
    cyc(); fetch_req_i = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule